// File: doc/BRIEF.md
# Vectored Interrupt Arbiter with Per-Source Descriptors

This block sits between a group of level-sensitive peripheral interrupt lines and a processor core. Software configures every source through a write-only register port. A source's configuration holds an enable, a priority level, a handler address, a register-set index and a flag that makes the source non-maskable. On every clock the block ranks the requests that qualify and offers the core one winner. The winner comes as a registered descriptor with the source number, the handler address, the register-set index, the level and a non-maskable marker.

The core supplies its global interrupt enable and its current execution level. A leveled request qualifies only when it is enabled, its line is high, the global enable is set and its level is strictly above the core's level. A non-maskable source ignores the global enable and the core level, and it outranks every leveled source. Once a descriptor is offered it stays fixed until the core acknowledges it or the source's line drops. Arbitration then resumes on the following edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every source is disabled and not non-maskable, so `irq_valid` stays low even with all request lines high, until software configures a source.
- R2: A write with `cfg_we` high stores `cfg_wdata` for the source numbered `cfg_addr`. The fields are: handler address in bits [15:0], level in [18:16], register-set index in [20:19], enable in bit 21, non-maskable flag in bit 22. A write to an address at or above the number of sources changes no source.
- R3: A leveled source qualifies only when its request line is high, its enable is set, `core_ie` is high and its level is strictly greater than `core_level`.
- R4: Among qualifying leveled sources, the highest level wins, and on equal levels the lowest source number wins.
- R5: An enabled non-maskable source with its line high qualifies whatever `core_ie` and `core_level` are, and it outranks every leveled source. Among such sources the lowest number wins. It is presented with `irq_nmi` = 1 and `irq_level` = 0.
- R6: When `irq_valid` is low and some source qualifies, the next clock edge raises `irq_valid`. The same edge presents the winner's number on `irq_id` and its handler address, register-set index and level.
- R7: While `irq_valid` is high, `irq_ack` is low and the presented source's line stays high, all descriptor outputs hold their values, even if a higher-ranked request appears.
- R8: `irq_ack` high while `irq_valid` is high clears `irq_valid` at the next edge. The edge after that arbitrates afresh.
- R9: If the presented source's request line drops before acknowledge, `irq_valid` falls at the next edge.
- R10: A source whose enable bit is clear is never presented, whatever its request line, level or non-maskable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ID_W | Source number to configure |
| cfg_wdata | input | 23 | Packed source configuration |
| src_req | input | N_SRC | Level-sensitive request lines |
| core_ie | input | 1 | Core global interrupt enable |
| core_level | input | 3 | Core current interrupt level |
| irq_ack | input | 1 | Core acknowledge of the presented interrupt |
| irq_valid | output | 1 | A descriptor is being presented |
| irq_id | output | ID_W | Number of the presented source |
| irq_vector | output | 16 | Handler address |
| irq_rset | output | 2 | Register-set index |
| irq_level | output | 3 | Interrupt level (0 for non-maskable) |
| irq_nmi | output | 1 | Presented interrupt is non-maskable |

## Verification
The bench builds the block with six sources, which is not a power of two. The 3-bit configuration address can then reach two numbers that belong to no source, and the bench writes to them to show that no real source is changed. With the 3-bit level width the bench can use level 7 for both a source and the core, which puts the strict-greater comparison at the top of its range. A behavioural model ranks the candidates with a numeric score and is compared with every output on every clock.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    parameter int LVL_W  = 3;
    parameter int VEC_W  = 16;
    parameter int RSET_W = 2;

    // Packed per-source configuration; bit order defines the write word layout
    typedef struct packed {
        logic              nmi;
        logic              en;
        logic [RSET_W-1:0] rset;
        logic [LVL_W-1:0]  lvl;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;

    localparam int CFG_W = $bits(src_cfg_t);

    // What the core receives with the valid strobe
    typedef struct packed {
        logic              nmi;
        logic [RSET_W-1:0] rset;
        logic [LVL_W-1:0]  lvl;
        logic [VEC_W-1:0]  vec;
    } irq_desc_t;

    // True when candidate a strictly beats incumbent b
    function automatic logic outranks(input logic a_nmi, input logic [LVL_W-1:0] a_lvl,
                                      input logic b_nmi, input logic [LVL_W-1:0] b_lvl);
        if (a_nmi != b_nmi)
            return a_nmi;
        return !a_nmi && (a_lvl > b_lvl);
    endfunction

    function automatic irq_desc_t to_desc(input src_cfg_t c);
        irq_desc_t d;
        d.nmi  = c.nmi;
        d.rset = c.rset;
        d.lvl  = c.nmi ? '0 : c.lvl;
        d.vec  = c.vec;
        return d;
    endfunction

endpackage

// File: rtl/ivc_cfg_bank.sv
module ivc_cfg_bank
    import ivc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [ID_W-1:0]  addr,
    input  logic [CFG_W-1:0] wdata,
    output src_cfg_t         cfg_o [N_SRC]
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                cfg_o[g] <= '0;
            else if (we && addr == ID_W'(g))
                cfg_o[g] <= src_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int ID_W  = 3
) (
    input  src_cfg_t          cfg      [N_SRC],
    input  logic [N_SRC-1:0]  src_req,
    input  logic              core_ie,
    input  logic [LVL_W-1:0]  core_level,
    output logic              found,
    output logic [ID_W-1:0]   win_id,
    output irq_desc_t         win_desc
);

    logic [N_SRC-1:0] elig;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = src_req[g] && cfg[g].en &&
                         (cfg[g].nmi || (core_ie && (cfg[g].lvl > core_level)));
    end

    logic             best_nmi;
    logic [LVL_W-1:0] best_lvl;

    // Ascending scan with strict comparison keeps the lowest index on ties
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_desc = '0;
        best_nmi = 1'b0;
        best_lvl = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!found || outranks(cfg[i].nmi, cfg[i].lvl, best_nmi, best_lvl))) begin
                found    = 1'b1;
                win_id   = ID_W'(i);
                win_desc = to_desc(cfg[i]);
                best_nmi = cfg[i].nmi;
                best_lvl = cfg[i].lvl;
            end
        end
    end

endmodule

// File: rtl/ivc_present.sv
module ivc_present
    import ivc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             found,
    input  logic [ID_W-1:0]  win_id,
    input  irq_desc_t        win_desc,
    input  logic [N_SRC-1:0] src_req,
    input  logic             ack,
    output logic             valid_o,
    output logic [ID_W-1:0]  id_o,
    output irq_desc_t        desc_o
);

    logic held_live;
    assign held_live = src_req[id_o];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            id_o    <= '0;
            desc_o  <= '0;
        end else if (valid_o) begin
            if (ack || !held_live)
                valid_o <= 1'b0;
        end else if (found) begin
            valid_o <= 1'b1;
            id_o    <= win_id;
            desc_o  <= win_desc;
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              core_ie,
    input  logic [LVL_W-1:0]  core_level,
    input  logic              irq_ack,
    output logic              irq_valid,
    output logic [ID_W-1:0]   irq_id,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [RSET_W-1:0] irq_rset,
    output logic [LVL_W-1:0]  irq_level,
    output logic              irq_nmi
);

    src_cfg_t         cfg [N_SRC];
    logic             arb_found;
    logic [ID_W-1:0]  arb_id;
    irq_desc_t        arb_desc;
    irq_desc_t        out_desc;

    ivc_cfg_bank #(.N_SRC(N_SRC), .ID_W(ID_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    ivc_arbiter #(.N_SRC(N_SRC), .ID_W(ID_W)) u_arb (
        .cfg        (cfg),
        .src_req    (src_req),
        .core_ie    (core_ie),
        .core_level (core_level),
        .found      (arb_found),
        .win_id     (arb_id),
        .win_desc   (arb_desc)
    );

    ivc_present #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pres (
        .clk      (clk),
        .rst      (rst),
        .found    (arb_found),
        .win_id   (arb_id),
        .win_desc (arb_desc),
        .src_req  (src_req),
        .ack      (irq_ack),
        .valid_o  (irq_valid),
        .id_o     (irq_id),
        .desc_o   (out_desc)
    );

    assign irq_vector = out_desc.vec;
    assign irq_rset   = out_desc.rset;
    assign irq_level  = out_desc.lvl;
    assign irq_nmi    = out_desc.nmi;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import ivc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int ID_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [N_SRC-1:0]  src_req,
    input logic              irq_ack,
    input logic              irq_valid,
    input logic [ID_W-1:0]   irq_id,
    input logic [VEC_W-1:0]  irq_vector,
    input logic [RSET_W-1:0] irq_rset,
    input logic [LVL_W-1:0]  irq_level,
    input logic              irq_nmi
);

    logic [N_SRC-1:0] req_q;
    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= src_req;
    end

    // R7
    hold_desc_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !irq_ack && src_req[irq_id]) |=>
        (irq_valid && $stable(irq_id) && $stable(irq_vector) &&
         $stable(irq_rset) && $stable(irq_level) && $stable(irq_nmi)));

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_ack) |=> !irq_valid);

    // R9
    drop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !src_req[irq_id]) |=> !irq_valid);

    // R5
    nmi_no_level_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_nmi) |-> (irq_level == '0));

    // R6
    rise_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_valid) |-> req_q[irq_id]);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_req    (src_req),
    .irq_ack    (irq_ack),
    .irq_valid  (irq_valid),
    .irq_id     (irq_id),
    .irq_vector (irq_vector),
    .irq_rset   (irq_rset),
    .irq_level  (irq_level),
    .irq_nmi    (irq_nmi)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam int N  = 6;
    localparam int IW = 3;
    localparam int CW = 23;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [N-1:0]  src_req = '0;
    logic          core_ie = 1'b0;
    logic [2:0]    core_level = '0;
    logic          irq_ack = 1'b0;
    logic          irq_valid;
    logic [IW-1:0] irq_id;
    logic [15:0]   irq_vector;
    logic [1:0]    irq_rset;
    logic [2:0]    irq_level;
    logic          irq_nmi;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    irq_vector_ctrl #(.N_SRC(N)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .src_req(src_req), .core_ie(core_ie), .core_level(core_level), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_id(irq_id), .irq_vector(irq_vector), .irq_rset(irq_rset),
        .irq_level(irq_level), .irq_nmi(irq_nmi)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference ----------------
    int  m_vec [N];
    int  m_lvl [N];
    int  m_rs  [N];
    bit  m_en  [N];
    bit  m_nm  [N];
    bit  e_valid;
    int  e_id, e_vec, e_rs, e_lvl;
    bit  e_nmi;
    int  best, bscore, sc;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_vec[i] = 0; m_lvl[i] = 0; m_rs[i] = 0; m_en[i] = 0; m_nm[i] = 0;
            end
            e_valid = 0;
        end else begin
            best = -1;
            bscore = -1;
            for (int i = 0; i < N; i++) begin
                sc = -1;
                if (src_req[i] && m_en[i]) begin
                    if (m_nm[i]) sc = 100;
                    else if (core_ie && m_lvl[i] > int'(core_level)) sc = m_lvl[i];
                end
                if (sc > bscore) begin bscore = sc; best = i; end
            end
            if (e_valid) begin
                if (irq_ack || !src_req[e_id]) e_valid = 0;
            end else if (best >= 0) begin
                e_valid = 1;
                e_id  = best;
                e_vec = m_vec[best];
                e_rs  = m_rs[best];
                e_nmi = m_nm[best];
                e_lvl = m_nm[best] ? 0 : m_lvl[best];
            end
            if (cfg_we && int'(cfg_addr) < N) begin
                m_vec[cfg_addr] = int'(cfg_wdata[15:0]);
                m_lvl[cfg_addr] = int'(cfg_wdata[18:16]);
                m_rs[cfg_addr]  = int'(cfg_wdata[20:19]);
                m_en[cfg_addr]  = cfg_wdata[21];
                m_nm[cfg_addr]  = cfg_wdata[22];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model (R6 descriptor contents)
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk("R6 model valid", int'(irq_valid), int'(e_valid));
            if (e_valid && irq_valid) begin
                chk("R6 model id",     int'(irq_id),     e_id);
                chk("R6 model vector", int'(irq_vector), e_vec);
                chk("R6 model rset",   int'(irq_rset),   e_rs);
                chk("R6 model level",  int'(irq_level),  e_lvl);
                chk("R6 model nmi",    int'(irq_nmi),    int'(e_nmi));
            end
        end
    end

    function automatic logic [CW-1:0] mk(input bit nmi, input bit en, input int rs,
                                         input int lvl, input int vec);
        return {nmi, en, 2'(rs), 3'(lvl), 16'(vec)};
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wcfg(input int a, input logic [CW-1:0] d);
        cfg_we = 1'b1; cfg_addr = IW'(a); cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 20000);
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 reset valid", int'(irq_valid), 0);

        // R1: all lines high, nothing configured
        src_req = '1; core_ie = 1'b1; core_level = 0;
        step(); step();
        chk("R1 unconfigured valid", int'(irq_valid), 0);
        src_req = '0;

        wcfg(2, mk(0, 1, 1, 3, 'h1200));
        wcfg(4, mk(0, 1, 2, 5, 'h1400));
        src_req = 6'b010100;
        step();
        // R6 / R2 fields
        chk("R6 valid", int'(irq_valid), 1);
        chk("R4 higher level id", int'(irq_id), 4);
        chk("R2 vector field", int'(irq_vector), 'h1400);
        chk("R2 rset field", int'(irq_rset), 2);
        chk("R2 level field", int'(irq_level), 5);

        // R7: higher-ranked arrival while held
        src_req = 6'b110100;
        wcfg(5, mk(0, 1, 3, 7, 'h1500));
        step();
        chk("R7 held id", int'(irq_id), 4);
        chk("R7 held vector", int'(irq_vector), 'h1400);

        // R8: ack then re-arbitration
        ack();
        chk("R8 valid after ack", int'(irq_valid), 0);
        step();
        chk("R8 rearb id", int'(irq_id), 5);
        chk("R8 rearb level", int'(irq_level), 7);

        // R9: presented line drops
        src_req = 6'b010100;
        step();
        chk("R9 valid after drop", int'(irq_valid), 0);
        step();
        chk("R9 next winner", int'(irq_id), 4);

        // R3: strict comparison with core level
        core_level = 5;
        ack();
        step(); step();
        chk("R3 equal level blocked", int'(irq_valid), 0);
        core_level = 4;
        step();
        chk("R3 greater level passes", int'(irq_id), 4);

        // R4: tie on level, lowest index wins
        src_req = '0;
        step();
        core_level = 0;
        wcfg(1, mk(0, 1, 0, 5, 'h1100));
        src_req = 6'b010110;
        step();
        chk("R4 tie id", int'(irq_id), 1);
        chk("R4 tie vector", int'(irq_vector), 'h1100);

        // R3: global enable low blocks leveled sources
        src_req = '0;
        step();
        core_ie = 1'b0;
        src_req = 6'b110110;
        step(); step();
        chk("R3 core_ie low", int'(irq_valid), 0);

        // R5: NMI bypasses core_ie and core_level
        core_level = 7;
        wcfg(0, mk(1, 1, 1, 2, 'h1000));
        src_req = 6'b110111;
        step();
        chk("R5 nmi valid", int'(irq_valid), 1);
        chk("R5 nmi id", int'(irq_id), 0);
        chk("R5 nmi flag", int'(irq_nmi), 1);
        chk("R5 nmi level zero", int'(irq_level), 0);
        chk("R5 nmi rset", int'(irq_rset), 1);

        // R5: NMI outranks a level-7 source, and lowest NMI index wins
        src_req = '0;
        step();
        core_ie = 1'b1; core_level = 0;
        wcfg(3, mk(1, 1, 2, 0, 'h1300));
        src_req = 6'b101001;
        step();
        chk("R5 outranks leveled", int'(irq_id), 0);
        src_req = 6'b101000;
        step(); step();
        chk("R5 nmi over level 7", int'(irq_id), 3);

        // R10: disabled source never presented
        src_req = '0;
        step();
        wcfg(5, mk(1, 0, 3, 7, 'h1500));
        src_req = 6'b100000;
        step(); step();
        chk("R10 disabled", int'(irq_valid), 0);

        // R2: writes beyond the source count change nothing
        src_req = '0;
        wcfg(6, mk(1, 1, 3, 7, 'hDEAD));
        wcfg(7, mk(1, 1, 3, 7, 'hBEEF));
        src_req = 6'b000010;
        step();
        chk("R2 out-of-range id", int'(irq_id), 1);
        chk("R2 out-of-range vector", int'(irq_vector), 'h1100);
        chk("R2 out-of-range nmi", int'(irq_nmi), 0);

        src_req = '0;
        step(); step();
        finish_run();
    end

endmodule